// File: doc/BRIEF.md
# Programmable Almost-Flag Offset Unit

This unit sits beside the storage of a dual-clock FIFO. It keeps two threshold offsets: one for the almost-empty flag and one for the almost-full flag. From these offsets and the occupancy counts it produces three registered flags: almost-empty, almost-full and half-full. The FIFO supplies the occupancy counts, one seen from the write side and one seen from the read side. The unit does not hold the FIFO data itself.

Two strap inputs are captured on a master reset. The load-select strap fixes how the offsets are programmed and what their default values are. The first option is parallel loading from a data bus, with both offsets defaulting to 127. The second is serial loading, one bit per write clock, with both offsets defaulting to 1023. The fall-through strap adds one word to the maximum depth, which moves the almost-full and half-full boundaries. A partial reset restarts the load and readback sequences and returns the flags to their empty-FIFO values, but it keeps the offsets and the captured straps.

Both offsets can be read back in parallel on the read clock under either loading method. A retransmit request freezes the almost-empty flag for two read-clock edges so that the read side can restart cleanly.

Top module: `afo_flag_unit`

## Requirements
- R1: Master reset (`mrst_i` high at a write-clock edge) captures `ld_sel_i` and `fwft_i`; only another master reset changes them. At the edge after a master reset or partial reset, `almost_empty_o` is 1, `almost_full_o` is 0, `half_full_o` is 0 and `rb_data_o` is 0.
- R2: When `ld_sel_i` is 0 at master reset, parallel loading is selected and both offsets become 127.
- R3: When `ld_sel_i` is 1 at master reset, serial loading is selected and both offsets become 1023.
- R4: In parallel mode, each write-clock edge with `ld_en_i` high stores `ld_data_i` into the next offset in turn: almost-empty offset first, then almost-full offset, then wrapping back. In serial mode, `ld_en_i` has no effect on the offsets.
- R5: In serial mode, each write-clock edge with `ser_en_i` high stores `ser_i` as the next offset bit. Bits go least significant first, OFFW bits into the almost-empty offset and then OFFW bits into the almost-full offset, then the sequence wraps. In parallel mode, `ser_en_i` has no effect on the offsets.
- R6: Each read-clock edge with `rd_en_i` high loads `rb_data_o` with the next offset in turn, almost-empty first and then almost-full. This works in either loading mode. Without `rd_en_i`, `rb_data_o` holds its value.
- R7: Partial reset keeps both offsets and the loading mode. After it, the next parallel load and the next readback start again at the almost-empty offset.
- R8: `almost_empty_o` is registered on the read clock. It is 1 when `rd_count_i` is less than or equal to the almost-empty offset.
- R9: `almost_full_o` is registered on the write clock. It is 1 when `wr_count_i` plus the almost-full offset is at least the maximum depth. The maximum depth is DEPTH, or DEPTH+1 when fall-through was strapped.
- R10: `half_full_o` is registered on the write clock. It is 1 when `wr_count_i` is at least DEPTH/2+1, or DEPTH/2+2 when fall-through was strapped.
- R11: When `retx_i` is high at a read-clock edge, `almost_empty_o` keeps its value at that edge and at the next one. It takes a fresh value from `rd_count_i` at the second edge after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write-domain clock |
| rclk_i | input | 1 | Read-domain clock |
| mrst_i | input | 1 | Master reset, synchronous, active high, applied to both domains |
| prst_i | input | 1 | Partial reset, synchronous, active high, applied to both domains |
| ld_sel_i | input | 1 | Load-method strap (0 parallel, 1 serial), captured at master reset |
| fwft_i | input | 1 | Fall-through strap, captured at master reset |
| ser_en_i | input | 1 | Serial load enable, write clock |
| ser_i | input | 1 | Serial offset bit |
| ld_en_i | input | 1 | Parallel load enable, write clock |
| ld_data_i | input | OFFW | Parallel offset value |
| rd_en_i | input | 1 | Readback enable, read clock |
| retx_i | input | 1 | Retransmit request, read clock |
| wr_count_i | input | CW | Occupancy as seen in the write domain |
| rd_count_i | input | CW | Occupancy as seen in the read domain |
| almost_empty_o | output | 1 | Almost-empty flag |
| almost_full_o | output | 1 | Almost-full flag |
| half_full_o | output | 1 | Half-full flag |
| rb_data_o | output | OFFW | Offset readback data |

## Verification
The bench builds the unit with DEPTH=256 and OFFW=10. This keeps the serial load to twenty cycles and the count width to nine bits. It also makes the 1023 default larger than the whole depth, so the almost-full and almost-empty flags must stay set at every occupancy in that case. With a depth this small, the half-full and almost-full boundaries in both depth modes, and every offset value below the depth, can be reached in a few hundred cycles. Random counts and random offsets are mixed with directed edge points on each threshold.

// File: rtl/afo_pkg.sv
`timescale 1ns/1ps
package afo_pkg;

    typedef enum logic {
        LOAD_PARALLEL = 1'b0,
        LOAD_SERIAL   = 1'b1
    } load_mode_e;

    typedef enum logic {
        SEL_EMPTY = 1'b0,
        SEL_FULL  = 1'b1
    } off_sel_e;

    typedef struct packed {
        load_mode_e mode;
        logic       fall_through;
    } strap_cfg_t;

    localparam int unsigned DFLT_OFF_PARALLEL = 127;
    localparam int unsigned DFLT_OFF_SERIAL   = 1023;

    function automatic int unsigned default_offset(input load_mode_e m);
        return (m == LOAD_SERIAL) ? DFLT_OFF_SERIAL : DFLT_OFF_PARALLEL;
    endfunction

    function automatic off_sel_e next_sel(input off_sel_e s);
        return (s == SEL_EMPTY) ? SEL_FULL : SEL_EMPTY;
    endfunction

    // Occupancy at which half-full turns on, for a given maximum depth.
    function automatic int unsigned half_mark(input int unsigned max_depth);
        return (max_depth + 1) / 2 + 1;
    endfunction

endpackage

// File: rtl/afo_offset_regs.sv
`timescale 1ns/1ps
module afo_offset_regs
    import afo_pkg::*;
#(
    parameter int OFFW = 13
) (
    input  logic            clk,
    input  logic            mrst,
    input  logic            prst,
    input  logic            ld_sel,
    input  logic            fwft,
    input  logic            ser_en,
    input  logic            ser_bit,
    input  logic            ld_en,
    input  logic [OFFW-1:0] ld_data,
    output strap_cfg_t      cfg,
    output logic [OFFW-1:0] off_e,
    output logic [OFFW-1:0] off_f
);
    localparam int BITW = $clog2(2 * OFFW);
    localparam logic [BITW-1:0] LAST_BIT = BITW'(2 * OFFW - 1);

    load_mode_e      strap_mode;
    logic [OFFW-1:0] strap_dflt;
    logic [BITW-1:0] bit_idx;
    off_sel_e        psel;
    logic [OFFW-1:0] ser_e_n;
    logic [OFFW-1:0] ser_f_n;

    assign strap_mode = load_mode_e'(ld_sel);
    assign strap_dflt = OFFW'(default_offset(strap_mode));

    // Serial bit placement: bit index selects one offset bit
    always_comb begin
        ser_e_n = off_e;
        ser_f_n = off_f;
        for (int i = 0; i < OFFW; i++) begin
            if (bit_idx == BITW'(i))        ser_e_n[i] = ser_bit;
            if (bit_idx == BITW'(i + OFFW)) ser_f_n[i] = ser_bit;
        end
    end

    always_ff @(posedge clk) begin
        if (mrst) begin
            cfg.mode         <= strap_mode;
            cfg.fall_through <= fwft;
            off_e            <= strap_dflt;
            off_f            <= strap_dflt;
            bit_idx          <= '0;
            psel             <= SEL_EMPTY;
        end else if (prst) begin
            bit_idx <= '0;
            psel    <= SEL_EMPTY;
        end else if (cfg.mode == LOAD_SERIAL) begin
            if (ser_en) begin
                off_e   <= ser_e_n;
                off_f   <= ser_f_n;
                bit_idx <= (bit_idx == LAST_BIT) ? '0 : bit_idx + 1'b1;
            end
        end else begin
            if (ld_en) begin
                if (psel == SEL_EMPTY) off_e <= ld_data;
                else                   off_f <= ld_data;
                psel <= next_sel(psel);
            end
        end
    end
endmodule

// File: rtl/afo_wflags.sv
`timescale 1ns/1ps
module afo_wflags
    import afo_pkg::*;
#(
    parameter int DEPTH = 8192,
    parameter int OFFW  = 13,
    parameter int CW    = 14
) (
    input  logic            clk,
    input  logic            mrst,
    input  logic            prst,
    input  logic            fall_through,
    input  logic [OFFW-1:0] off_f,
    input  logic [CW-1:0]   wr_count,
    output logic            almost_full,
    output logic            half_full
);
    logic [31:0] max_depth;
    logic [31:0] level;
    logic        paf_hit;
    logic        hf_hit;

    assign max_depth = 32'(DEPTH) + 32'(fall_through);
    assign level     = 32'(wr_count);
    assign paf_hit   = (level + 32'(off_f)) >= max_depth;
    assign hf_hit    = level >= half_mark(max_depth);

    always_ff @(posedge clk) begin
        if (mrst || prst) begin
            almost_full <= 1'b0;
            half_full   <= 1'b0;
        end else begin
            almost_full <= paf_hit;
            half_full   <= hf_hit;
        end
    end
endmodule

// File: rtl/afo_rflags.sv
`timescale 1ns/1ps
module afo_rflags #(
    parameter int OFFW = 13,
    parameter int CW   = 14
) (
    input  logic            clk,
    input  logic            mrst,
    input  logic            prst,
    input  logic            retx,
    input  logic [OFFW-1:0] off_e,
    input  logic [CW-1:0]   rd_count,
    output logic            almost_empty
);
    logic hold_q;
    logic frozen;
    logic pae_hit;

    assign frozen  = retx || hold_q;
    assign pae_hit = 32'(rd_count) <= 32'(off_e);

    always_ff @(posedge clk) begin
        if (mrst || prst) begin
            hold_q       <= 1'b0;
            almost_empty <= 1'b1;
        end else begin
            hold_q <= retx;
            if (!frozen) almost_empty <= pae_hit;
        end
    end
endmodule

// File: rtl/afo_readback.sv
`timescale 1ns/1ps
module afo_readback
    import afo_pkg::*;
#(
    parameter int OFFW = 13
) (
    input  logic            clk,
    input  logic            mrst,
    input  logic            prst,
    input  logic            rd_en,
    input  logic [OFFW-1:0] off_e,
    input  logic [OFFW-1:0] off_f,
    output logic [OFFW-1:0] rb_data
);
    off_sel_e rsel;

    always_ff @(posedge clk) begin
        if (mrst || prst) begin
            rsel    <= SEL_EMPTY;
            rb_data <= '0;
        end else if (rd_en) begin
            rb_data <= (rsel == SEL_EMPTY) ? off_e : off_f;
            rsel    <= next_sel(rsel);
        end
    end
endmodule

// File: rtl/afo_flag_unit.sv
`timescale 1ns/1ps
module afo_flag_unit
    import afo_pkg::*;
#(
    parameter int  DEPTH = 8192,
    parameter int  OFFW  = 13,
    localparam int CW    = $clog2(DEPTH + 2)
) (
    input  logic            wclk_i,
    input  logic            rclk_i,
    input  logic            mrst_i,
    input  logic            prst_i,
    input  logic            ld_sel_i,
    input  logic            fwft_i,
    input  logic            ser_en_i,
    input  logic            ser_i,
    input  logic            ld_en_i,
    input  logic [OFFW-1:0] ld_data_i,
    input  logic            rd_en_i,
    input  logic            retx_i,
    input  logic [CW-1:0]   wr_count_i,
    input  logic [CW-1:0]   rd_count_i,
    output logic            almost_empty_o,
    output logic            almost_full_o,
    output logic            half_full_o,
    output logic [OFFW-1:0] rb_data_o
);
    strap_cfg_t      cfg;
    logic [OFFW-1:0] off_e;
    logic [OFFW-1:0] off_f;

    afo_offset_regs #(.OFFW(OFFW)) u_regs (
        .clk     (wclk_i),
        .mrst    (mrst_i),
        .prst    (prst_i),
        .ld_sel  (ld_sel_i),
        .fwft    (fwft_i),
        .ser_en  (ser_en_i),
        .ser_bit (ser_i),
        .ld_en   (ld_en_i),
        .ld_data (ld_data_i),
        .cfg     (cfg),
        .off_e   (off_e),
        .off_f   (off_f)
    );

    afo_wflags #(.DEPTH(DEPTH), .OFFW(OFFW), .CW(CW)) u_wflags (
        .clk          (wclk_i),
        .mrst         (mrst_i),
        .prst         (prst_i),
        .fall_through (cfg.fall_through),
        .off_f        (off_f),
        .wr_count     (wr_count_i),
        .almost_full  (almost_full_o),
        .half_full    (half_full_o)
    );

    afo_rflags #(.OFFW(OFFW), .CW(CW)) u_rflags (
        .clk          (rclk_i),
        .mrst         (mrst_i),
        .prst         (prst_i),
        .retx         (retx_i),
        .off_e        (off_e),
        .rd_count     (rd_count_i),
        .almost_empty (almost_empty_o)
    );

    afo_readback #(.OFFW(OFFW)) u_rb (
        .clk     (rclk_i),
        .mrst    (mrst_i),
        .prst    (prst_i),
        .rd_en   (rd_en_i),
        .off_e   (off_e),
        .off_f   (off_f),
        .rb_data (rb_data_o)
    );
endmodule

// File: rtl/afo_flag_unit_chk.sv
`timescale 1ns/1ps
module afo_flag_unit_chk #(
    parameter int DEPTH = 8192,
    parameter int OFFW  = 13,
    parameter int CW    = 14
) (
    input logic            wclk_i,
    input logic            rclk_i,
    input logic            mrst_i,
    input logic            prst_i,
    input logic            rd_en_i,
    input logic            retx_i,
    input logic [CW-1:0]   wr_count_i,
    input logic [CW-1:0]   rd_count_i,
    input logic            almost_empty_o,
    input logic            almost_full_o,
    input logic            half_full_o,
    input logic [OFFW-1:0] rb_data_o
);
    logic prev_retx_q;

    always_ff @(posedge rclk_i) begin
        if (mrst_i || prst_i) prev_retx_q <= 1'b0;
        else                  prev_retx_q <= retx_i;
    end

    AST_RESET_WFLAGS: assert property (@(posedge wclk_i)
        mrst_i |=> (!almost_full_o && !half_full_o)); // R1

    AST_RESET_RFLAG: assert property (@(posedge rclk_i)
        mrst_i |=> (almost_empty_o && rb_data_o == '0)); // R1

    AST_RB_HOLD: assert property (@(posedge rclk_i) disable iff (mrst_i || prst_i)
        !rd_en_i |=> $stable(rb_data_o)); // R6

    AST_PAE_AT_ZERO: assert property (@(posedge rclk_i) disable iff (mrst_i || prst_i)
        (rd_count_i == '0 && !retx_i && !prev_retx_q) |=> almost_empty_o); // R8

    AST_PAE_RETX_FREEZE: assert property (@(posedge rclk_i) disable iff (mrst_i || prst_i)
        retx_i |=> $stable(almost_empty_o)); // R11

    AST_OVERFULL_FLAGS: assert property (@(posedge wclk_i) disable iff (mrst_i || prst_i)
        (32'(wr_count_i) > 32'(DEPTH)) |=> (almost_full_o && half_full_o)); // R9

    AST_HF_AT_ZERO: assert property (@(posedge wclk_i) disable iff (mrst_i || prst_i)
        (wr_count_i == '0) |=> !half_full_o); // R10
endmodule

bind afo_flag_unit afo_flag_unit_chk #(.DEPTH(DEPTH), .OFFW(OFFW), .CW(CW)) u_chk (
    .wclk_i         (wclk_i),
    .rclk_i         (rclk_i),
    .mrst_i         (mrst_i),
    .prst_i         (prst_i),
    .rd_en_i        (rd_en_i),
    .retx_i         (retx_i),
    .wr_count_i     (wr_count_i),
    .rd_count_i     (rd_count_i),
    .almost_empty_o (almost_empty_o),
    .almost_full_o  (almost_full_o),
    .half_full_o    (half_full_o),
    .rb_data_o      (rb_data_o)
);

// File: tb/afo_flag_unit_test.sv
`timescale 1ns/1ps
module afo_flag_unit_test;
    localparam int DEPTH = 256;
    localparam int OFFW  = 10;
    localparam int CW    = $clog2(DEPTH + 2);

    logic            clk = 1'b0;
    logic            mrst, prst, ld_sel, fwft, ser_en, ser_b, ld_en, rd_en, retx;
    logic [OFFW-1:0] ld_data;
    logic [CW-1:0]   wr_count, rd_count;
    logic            pae, paf, hf;
    logic [OFFW-1:0] rb;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;
    int exp_e, exp_f, exp_fw;

    afo_flag_unit #(.DEPTH(DEPTH), .OFFW(OFFW)) uut (
        .wclk_i(clk), .rclk_i(clk), .mrst_i(mrst), .prst_i(prst),
        .ld_sel_i(ld_sel), .fwft_i(fwft), .ser_en_i(ser_en), .ser_i(ser_b),
        .ld_en_i(ld_en), .ld_data_i(ld_data), .rd_en_i(rd_en), .retx_i(retx),
        .wr_count_i(wr_count), .rd_count_i(rd_count),
        .almost_empty_o(pae), .almost_full_o(paf), .half_full_o(hf), .rb_data_o(rb)
    );

    always #2.5 clk = ~clk;

    function automatic int f_pae(int c, int e);
        return (c <= e) ? 1 : 0;
    endfunction
    function automatic int f_paf(int c, int f, int fw);
        return (c + f >= DEPTH + fw) ? 1 : 0;
    endfunction
    function automatic int f_hf(int c, int fw);
        return (c >= DEPTH / 2 + 1 + fw) ? 1 : 0;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_mrst(input logic sel, input logic fw);
        ld_sel = sel; fwft = fw; mrst = 1'b1;
        step();
        mrst = 1'b0;
        exp_e = sel ? 1023 : 127;
        exp_f = exp_e;
        exp_fw = int'(fw);
    endtask

    task automatic read_offs(output int e, output int f);
        rd_en = 1'b1; step(); e = int'(rb);
        step(); f = int'(rb);
        rd_en = 1'b0;
    endtask

    task automatic check_offs(input string req);
        int e, f;
        read_offs(e, f);
        chk({req, " readback empty offset"}, e, exp_e);
        chk({req, " readback full offset"}, f, exp_f);
    endtask

    task automatic par_load(input int e, input int f);
        ld_en = 1'b1; ld_data = OFFW'(e); step();
        ld_data = OFFW'(f); step();
        ld_en = 1'b0;
    endtask

    task automatic ser_load(input int e, input int f);
        ser_en = 1'b1;
        for (int i = 0; i < 2 * OFFW; i++) begin
            ser_b = (i < OFFW) ? e[i] : f[i - OFFW];
            step();
        end
        ser_en = 1'b0;
    endtask

    task automatic flags_at(input int w, input int r, input string tag);
        wr_count = CW'(w); rd_count = CW'(r);
        step();
        chk({"R8 ", tag}, int'(pae), f_pae(r, exp_e));
        chk({"R9 ", tag}, int'(paf), f_paf(w, exp_f, exp_fw));
        chk({"R10 ", tag}, int'(hf), f_hf(w, exp_fw));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        int e, f, tmp_e, tmp_f;
        void'($urandom(32'd20240611));
        mrst = 1'b1; prst = 1'b0; ld_sel = 1'b0; fwft = 1'b0;
        ser_en = 1'b0; ser_b = 1'b0; ld_en = 1'b0; ld_data = '0;
        rd_en = 1'b0; retx = 1'b0; wr_count = '0; rd_count = '0;
        #1;
        step(); step();
        // R1 reset state
        chk("R1 pae after reset", int'(pae), 1);
        chk("R1 paf after reset", int'(paf), 0);
        chk("R1 hf after reset", int'(hf), 0);
        chk("R1 readback after reset", int'(rb), 0);
        do_mrst(1'b0, 1'b0);

        // R2 parallel defaults, R6 readback order
        check_offs("R2 R6");

        // R10 standard-depth half-full edge
        flags_at(DEPTH / 2, 0, "hf edge below");
        flags_at(DEPTH / 2 + 1, 0, "hf edge at");

        // R4 parallel load with random values
        e = int'($urandom_range(DEPTH / 2, 1));
        f = int'($urandom_range(DEPTH / 2, 1));
        par_load(e, f);
        exp_e = e; exp_f = f;
        check_offs("R4 parallel");

        // R5 serial enable ignored in parallel mode
        ser_en = 1'b1;
        for (int i = 0; i < 2 * OFFW; i++) begin
            ser_b = 1'($urandom_range(1, 0));
            step();
        end
        ser_en = 1'b0;
        check_offs("R5 ignored in parallel mode");

        // R8 R9 R10 random occupancy
        for (int i = 0; i < 40; i++) begin
            flags_at(int'($urandom_range(DEPTH, 0)), int'($urandom_range(DEPTH, 0)), "random std");
        end
        flags_at(DEPTH - exp_f - 1, exp_e, "pae/paf edge");
        flags_at(DEPTH - exp_f, exp_e + 1, "pae/paf edge past");

        // R7 partial reset keeps offsets, restarts sequencers
        ld_en = 1'b1; ld_data = OFFW'(5); step(); ld_en = 1'b0;
        exp_e = 5;
        wr_count = CW'(DEPTH); rd_count = CW'(DEPTH);
        prst = 1'b1; step(); prst = 1'b0;
        chk("R7 pae after partial reset", int'(pae), 1);
        chk("R7 paf after partial reset", int'(paf), 0);
        chk("R7 hf after partial reset", int'(hf), 0);
        check_offs("R7 offsets kept");
        tmp_e = int'($urandom_range(DEPTH / 2, 1));
        tmp_f = int'($urandom_range(DEPTH / 2, 1));
        par_load(tmp_e, tmp_f);
        exp_e = tmp_e; exp_f = tmp_f;
        check_offs("R7 load restarts at empty offset");

        // R11 retransmit freezes almost-empty for two edges
        wr_count = '0; rd_count = '0; step();
        chk("R11 pae before retransmit", int'(pae), 1);
        rd_count = CW'(exp_e + 1); retx = 1'b1; step();
        chk("R11 pae frozen at sampling edge", int'(pae), 1);
        retx = 1'b0; step();
        chk("R11 pae frozen one edge later", int'(pae), 1);
        step();
        chk("R11 pae updated on second edge", int'(pae), 0);

        // R3 serial defaults, fall-through depth
        do_mrst(1'b1, 1'b1);
        check_offs("R3 serial defaults");
        flags_at(0, DEPTH, "1023 offset");
        flags_at(DEPTH / 2 + 1, 0, "fwft hf below");
        flags_at(DEPTH / 2 + 2, 0, "fwft hf at");

        // R5 serial load
        e = int'($urandom_range(DEPTH / 2, 1));
        f = int'($urandom_range(DEPTH / 2, 1));
        ser_load(e, f);
        exp_e = e; exp_f = f;
        check_offs("R5 serial load");

        // R4 parallel enable ignored in serial mode
        par_load(3, 4);
        check_offs("R4 ignored in serial mode");

        // R9 fall-through almost-full edge
        flags_at(DEPTH + 1 - exp_f - 1, exp_e, "fwft paf below");
        flags_at(DEPTH + 1 - exp_f, exp_e + 1, "fwft paf at");
        flags_at(DEPTH + 1, 0, "fwft max count");
        for (int i = 0; i < 30; i++) begin
            flags_at(int'($urandom_range(DEPTH + 1, 0)), int'($urandom_range(DEPTH + 1, 0)), "random fwft");
        end

        // R7 partial reset keeps serial mode and offsets
        prst = 1'b1; step(); prst = 1'b0;
        check_offs("R7 serial kept");
        ser_load(7, 9);
        exp_e = 7; exp_f = 9;
        check_offs("R7 serial restart");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule